// File: doc/BRIEF.md
# Programmable Agent Mealy Control Machine

This block decides, once per generation, what a single moving agent on a cellular grid does next. It holds a small Mealy state table that can be rewritten at run time. The table has one row per control state and one column per value of the move condition. Each entry gives a successor state and a one-bit turn choice. A fixed output stage turns that choice into a new heading and a four-valued action code.

At the start of each generation, the surrounding cell logic supplies the agent's present state, its heading and whether the cell in front is free, and raises `step`. One clock later the block presents the successor state, the new heading, the action and a move flag, together with a one-cycle `out_valid` pulse. These results stay unchanged until the next `step`.

Table entries are loaded through a simple write port. A synchronous reset restores the built-in six-state program.

Top module: `agent_ctrl_top`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs are registered to zero (`nxt_state`=0, `nxt_dir`=0, `act`=0, `mv`=0, `out_valid`=0) and the table is reloaded with the built-in program given in R6 and R7.
- R2: `step` high at one rising edge makes `out_valid` high for exactly the following cycle, with all results registered at that same edge.
- R3: When `move_ok`=0 (blocked), `mv` is 0 and `act` is a pure turn. The action code uses bit 1 as the move flag and bit 0 as the turn flag (1 = right), so a pure turn gives `act`=0 for a left turn and 1 for a right turn.
- R4: When `move_ok`=1 (free), `mv` is 1 and `act` is a turn-and-move: 2 for a left turn with a move, 3 for a right turn with a move.
- R5: Headings are 0=north, 1=east, 2=south, 3=west. A turn bit of 1 gives `nxt_dir` = `cur_dir`+1 mod 4. A turn bit of 0 gives `cur_dir`−1 mod 4.
- R6: The built-in blocked column maps states 0,1,2 to successors 1,2,0, each turning left, and maps states 3,4,5 to successors 4,5,3, each turning right.
- R7: The built-in free column maps states 0..5 to successors 3,1,5,0,4,2. Even states turn left and odd states turn right.
- R8: A write with `tbl_we`=1 at address a loads `{tbl_turn, tbl_next}` into the blocked entry of state a when a is 0..5, and into the free entry of state a−6 when a is 6..11. Addresses 12..15 change nothing.
- R9: A write and a `step` in the same cycle are resolved in that order: the lookup uses the entry as it was before the write, and the new entry applies from the next `step`.
- R10: A written successor of 6 or 7 is stored as 0.
- R11: A `cur_state` of 6 or 7 is looked up as state 0.
- R12: While `step` is low, `nxt_state`, `nxt_dir`, `act` and `mv` hold their values, and `out_valid` is 0.
- R13: Reset after table writes restores the built-in entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, reloads the built-in table |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 4 | Entry address: 0..5 blocked column, 6..11 free column |
| tbl_next | input | 3 | Successor state to write |
| tbl_turn | input | 1 | Turn bit to write (1 = right) |
| step | input | 1 | Start of generation: sample the inputs below |
| move_ok | input | 1 | 1 = front cell free, 0 = blocked |
| cur_dir | input | 2 | Present heading |
| cur_state | input | 3 | Present control state |
| nxt_state | output | 3 | Registered successor state |
| nxt_dir | output | 2 | Registered new heading |
| act | output | 2 | Registered action: bit1 move, bit0 right |
| mv | output | 1 | Registered move flag |
| out_valid | output | 1 | One-cycle pulse after a step |

## Verification
Every result depends on a single register stage, so each is due at the first rising edge after the edge that sampled `step`. The bench drives inputs on the falling edge, holds `step` for one cycle, and reads all outputs on the next falling edge, where `out_valid` must be high. A table write takes effect at its own edge. The bench therefore issues each write on its own cycle, or in the same cycle as a `step` when the read-before-write order is being checked. It then observes the effect through a later step. Hold behaviour is read several falling edges after a step, with `step` kept low throughout.

// File: rtl/agent_ctrl_pkg.sv
package agent_ctrl_pkg;

  // Built-in successor for flat entry index: blocked column first, then free.
  function automatic int dflt_next(input int idx);
    int k;
    if (idx < 3) return (idx + 1) % 3;
    if (idx < 6) return 3 + ((idx - 2) % 3);
    k = idx - 6;
    case (k)
      0: return 3;
      1: return 1;
      2: return 5;
      3: return 0;
      4: return 4;
      5: return 2;
      default: return 0;
    endcase
  endfunction

  // Built-in turn bit: 1 = right.
  function automatic bit dflt_turn(input int idx);
    if (idx < 6) return (idx >= 3);
    if (idx < 12) return ((idx - 6) % 2) == 1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/agent_rule_table.sv
module agent_rule_table
  import agent_ctrl_pkg::*;
#(
  parameter int N_STATES = 6,
  parameter int STATE_W  = 3,
  parameter int ENTRIES  = 2 * N_STATES,
  parameter int ADDR_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [STATE_W-1:0] wr_next,
  input  logic               wr_turn,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [STATE_W-1:0] rd_next,
  output logic               rd_turn
);

  localparam int EW = STATE_W + 1;

  logic [EW-1:0]      mem [ENTRIES];
  logic [STATE_W-1:0] wr_next_cl;
  logic               wr_hit;

  // Out-of-range successors collapse to state 0.
  assign wr_next_cl = ({1'b0, wr_next} < (STATE_W+1)'(N_STATES)) ? wr_next : '0;
  assign wr_hit     = wr_en && ({1'b0, wr_addr} < (ADDR_W+1)'(ENTRIES));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++)
        mem[i] <= {dflt_turn(i), STATE_W'(dflt_next(i))};
    end else if (wr_hit) begin
      mem[wr_addr] <= {wr_turn, wr_next_cl};
    end
  end

  assign {rd_turn, rd_next} = mem[rd_addr];

  // R10
  stored_next_range_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ({1'b0, rd_next} < (STATE_W+1)'(N_STATES)));

endmodule

// File: rtl/agent_turn_unit.sv
module agent_turn_unit #(
  parameter int DIR_W = 2
) (
  input  logic [DIR_W-1:0] dir_in,
  input  logic             turn_right,
  input  logic             can_move,
  output logic [DIR_W-1:0] dir_out,
  output logic [1:0]       act_code
);

  always_comb begin
    if (turn_right) dir_out = dir_in + DIR_W'(1);
    else            dir_out = dir_in - DIR_W'(1);
    act_code = {can_move, turn_right};
  end

endmodule

// File: rtl/agent_ctrl_top.sv
module agent_ctrl_top #(
  parameter int N_STATES = 6,
  parameter int STATE_W  = 3,
  parameter int DIR_W    = 2,
  parameter int ADDR_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tbl_we,
  input  logic [ADDR_W-1:0]  tbl_addr,
  input  logic [STATE_W-1:0] tbl_next,
  input  logic               tbl_turn,
  input  logic               step,
  input  logic               move_ok,
  input  logic [DIR_W-1:0]   cur_dir,
  input  logic [STATE_W-1:0] cur_state,
  output logic [STATE_W-1:0] nxt_state,
  output logic [DIR_W-1:0]   nxt_dir,
  output logic [1:0]         act,
  output logic               mv,
  output logic               out_valid
);

  localparam int ENTRIES = 2 * N_STATES;

  logic [STATE_W-1:0] row;
  logic [ADDR_W-1:0]  rd_idx;
  logic [STATE_W-1:0] lk_next;
  logic               lk_turn;
  logic [DIR_W-1:0]   dir_new;
  logic [1:0]         act_new;

  // Unused state codes fall back to the initial row.
  assign row    = ({1'b0, cur_state} < (STATE_W+1)'(N_STATES)) ? cur_state : '0;
  assign rd_idx = ADDR_W'(row) + (move_ok ? ADDR_W'(N_STATES) : '0);

  agent_rule_table #(
    .N_STATES (N_STATES),
    .STATE_W  (STATE_W),
    .ENTRIES  (ENTRIES),
    .ADDR_W   (ADDR_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_next (tbl_next),
    .wr_turn (tbl_turn),
    .rd_addr (rd_idx),
    .rd_next (lk_next),
    .rd_turn (lk_turn)
  );

  agent_turn_unit #(.DIR_W(DIR_W)) u_turn (
    .dir_in     (cur_dir),
    .turn_right (lk_turn),
    .can_move   (move_ok),
    .dir_out    (dir_new),
    .act_code   (act_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_state <= '0;
      nxt_dir   <= '0;
      act       <= '0;
      mv        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= step;
      if (step) begin
        nxt_state <= lk_next;
        nxt_dir   <= dir_new;
        act       <= act_new;
        mv        <= move_ok;
      end
    end
  end

  // R2
  valid_follows_step_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(step));

  // R3 R4
  move_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (mv == $past(move_ok)) && (act[1] == mv));

  // R5
  heading_step_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (nxt_dir == $past(cur_dir) + DIR_W'(1) && act[0]) ||
                  (nxt_dir == $past(cur_dir) - DIR_W'(1) && !act[0]));

  // R12
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !$past(rst)) |=> $stable(nxt_state) && $stable(nxt_dir) && $stable(act) && !out_valid);

endmodule

// File: tb/agent_ctrl_top_tb.sv
module agent_ctrl_top_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [2:0] tbl_next = '0;
  logic       tbl_turn = 1'b0;
  logic       step = 1'b0;
  logic       move_ok = 1'b0;
  logic [1:0] cur_dir = '0;
  logic [2:0] cur_state = '0;
  logic [2:0] nxt_state;
  logic [1:0] nxt_dir;
  logic [1:0] act;
  logic       mv;
  logic       out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agent_ctrl_top u_dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_next(tbl_next), .tbl_turn(tbl_turn), .step(step),
    .move_ok(move_ok), .cur_dir(cur_dir), .cur_state(cur_state),
    .nxt_state(nxt_state), .nxt_dir(nxt_dir), .act(act), .mv(mv),
    .out_valid(out_valid)
  );

  // {state, dir, m, exp_state, exp_dir, exp_act}
  localparam logic [12:0] VEC [12] = '{
    13'b000_00_0_001_11_00, 13'b001_01_0_010_00_00, 13'b010_10_0_000_01_00,
    13'b011_11_0_100_00_01, 13'b100_00_0_101_01_01, 13'b101_01_0_011_10_01,
    13'b000_10_1_011_01_10, 13'b001_11_1_001_00_11, 13'b010_00_1_101_11_10,
    13'b011_01_1_000_10_11, 13'b100_10_1_100_01_10, 13'b101_11_1_010_00_11
  };

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (valid,state,dir,act,mv)", req, got, exp);
    end
  endtask

  function automatic logic [8:0] pack_out(input logic v, input logic [2:0] s,
                                          input logic [1:0] d, input logic [1:0] a);
    return {v, s, d, a, a[1]};
  endfunction

  task automatic do_step(input logic [2:0] s, input logic [1:0] d, input logic m);
    @(negedge clk);
    cur_state = s; cur_dir = d; move_ok = m; step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [2:0] n, input logic t);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_next = n; tbl_turn = t;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_vec(input int i, input string req);
    logic [12:0] v;
    v = VEC[i];
    do_step(v[12:10], v[9:8], v[7]);
    check(req, {out_valid, nxt_state, nxt_dir, act, mv},
          pack_out(1'b1, v[6:4], v[3:2], v[1:0]));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [8:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs
    check("R1", {out_valid, nxt_state, nxt_dir, act, mv}, 9'b0);
    @(negedge clk);
    rst = 1'b0;

    // R8: addresses 12..15 must leave every entry alone (checked by walk below)
    for (int a = 12; a < 16; a++) do_write(4'(a), 3'd5, 1'b1);

    // R6 R7 R3 R4 R5: walk the built-in program
    for (int i = 0; i < 12; i++) run_vec(i, i < 6 ? "R6_R3_R5_R8" : "R7_R4_R5_R8");

    // R12: outputs hold while step is low
    held = {1'b0, nxt_state, nxt_dir, act, mv};
    repeat (4) @(negedge clk);
    check("R12", {out_valid, nxt_state, nxt_dir, act, mv}, held);

    // R8: write free entry of state 0 -> successor 4, right
    do_write(4'd6, 3'd4, 1'b1);
    do_step(3'd0, 2'd0, 1'b1);
    check("R8", {out_valid, nxt_state, nxt_dir, act, mv}, pack_out(1'b1, 3'd4, 2'd1, 2'd3));

    // R9: write blocked entry of state 1 in the same cycle as a step
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'd1; tbl_next = 3'd5; tbl_turn = 1'b1;
    cur_state = 3'd1; cur_dir = 2'd2; move_ok = 1'b0; step = 1'b1;
    @(negedge clk);
    tbl_we = 1'b0; step = 1'b0;
    check("R9", {out_valid, nxt_state, nxt_dir, act, mv}, pack_out(1'b1, 3'd2, 2'd1, 2'd0));
    do_step(3'd1, 2'd2, 1'b0);
    check("R9", {out_valid, nxt_state, nxt_dir, act, mv}, pack_out(1'b1, 3'd5, 2'd3, 2'd1));

    // R10: successor 7 stored as 0
    do_write(4'd2, 3'd7, 1'b0);
    do_step(3'd2, 2'd0, 1'b0);
    check("R10", {out_valid, nxt_state, nxt_dir, act, mv}, pack_out(1'b1, 3'd0, 2'd3, 2'd0));
    do_write(4'd9, 3'd6, 1'b1);
    do_step(3'd3, 2'd3, 1'b1);
    check("R10", {out_valid, nxt_state, nxt_dir, act, mv}, pack_out(1'b1, 3'd0, 2'd0, 2'd3));

    // R11: state codes 6 and 7 use row 0
    do_step(3'd6, 2'd0, 1'b0);
    check("R11", {out_valid, nxt_state, nxt_dir, act, mv}, pack_out(1'b1, 3'd1, 2'd3, 2'd0));
    do_step(3'd7, 2'd1, 1'b1);
    check("R11", {out_valid, nxt_state, nxt_dir, act, mv}, pack_out(1'b1, 3'd4, 2'd2, 2'd3));

    // R1 R13: reset restores outputs and built-in entries
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, nxt_state, nxt_dir, act, mv}, 9'b0);
    rst = 1'b0;
    run_vec(1, "R13");
    run_vec(2, "R13");
    run_vec(6, "R13");
    run_vec(9, "R13");

    finish_run();
  end

endmodule